// File: doc/BRIEF.md
# Serial LED Matrix Power-Up Sequencer

This block is the host-side controller for a serial LED dot-matrix module that is driven over four wires: a register-select line, an active-low chip enable, a shift clock and a serial data line. It also drives the module's active-low reset. A one-cycle start pulse runs the power-up sequence in a fixed order. First the module reset is held low. Then an all-zero pattern is shifted through the whole dot chain, so the display comes up blank. Last, control word 0 is written with the brightness value and the wake bit set.

After the sequence finishes, the block takes dot frames as parallel words through a valid/ready interface. It serializes each frame into a single transfer to the dot chain. Every transfer follows one bus order: set the register select, lower the enable, shift the bits MSB first on rising clock edges, raise the enable with the clock high, then drop the clock to latch the data.

The chain length, frame word width, clock divider, reset hold time and the default current setting are parameters.

Top module: `led_chain_init_seq`

## Requirements
- R1: While the controller is in reset and until a start is accepted, the module reset output is low, chip enable is high (inactive), the shift clock is low, and both busy and frame ready are low.
- R2: A start pulse keeps the module reset low for at least RST_HOLD controller clocks and then releases it. A start that arrives while busy is high is ignored and leaves the module reset high.
- R3: The first transfer after the reset release has the register select low and shifts exactly CHAIN_BITS zero bits.
- R4: The second transfer has the register select high and shifts 8 bits, MSB first. Bit 7 is 0 (this selects control word 0), bit 6 is 1 (wake), bits 5:4 hold CUR_SEL, and bits 3:0 hold the brightness sampled with the start pulse.
- R5: Busy goes high with an accepted start and stays high until the control-word transfer has latched. While busy is high, frame ready stays low even when frame valid is high.
- R6: In the running state, a frame is CHAIN_BITS/WORD_W words. It is sent as one transfer with the register select low: the first word goes first, each word MSB first. An idle gap between words keeps the transfer open.
- R7: The register select output changes only while chip enable is high, and only if it was also high in the previous cycle.
- R8: The data output changes only while the shift clock is low, and never in the cycle where the clock has just fallen. Each bit is stable for at least DIV-1 controller clocks before its rising edge.
- R9: Chip enable falls only while the shift clock is low. It rises only while the shift clock is high, and the next clock fall, with enable still high, is the latch edge.
- R10: A start accepted in the running state, with no frame open, repeats the whole sequence using the newly sampled brightness.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Controller reset, active low |
| start_i | input | 1 | One-cycle request to run the power-up sequence |
| bright_i | input | 4 | Brightness level, sampled with start |
| busy_o | output | 1 | High while the power-up sequence runs |
| frm_valid_i | input | 1 | Frame word valid |
| frm_data_i | input | WORD_W | Frame word, first-shifted bit in the MSB |
| frm_ready_o | output | 1 | Frame word accepted when high together with valid |
| disp_rst_n_o | output | 1 | Module reset, active low |
| disp_rs_o | output | 1 | Register select: low for dots, high for control |
| disp_ce_n_o | output | 1 | Module chip enable, active low |
| disp_sclk_o | output | 1 | Module shift clock |
| disp_din_o | output | 1 | Module serial data |

## Verification
The bench decodes the four-wire bus into transfers, each made of a select level, a bit count and a bit pattern. It compares them in order with the transfers it expects.

Frames of all ones, alternating 0xA5/0x5A bytes and a walking byte pattern are sent. Together these show that word order and bit order within a word are right and that no bit is dropped or repeated. Some frames have idle gaps between words, which shows that an open transfer survives a stall of the source.

Two power-up runs with different brightness values show that the brightness is sampled at start and placed in the low bits of the control word. A stray start during the sequence, and valid held high while busy, show that the block ignores both.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;

   typedef enum logic [2:0] {
      E_IDLE, E_SEL, E_CE, E_LOW, E_HIGH, E_HOLD, E_CEUP, E_LATCH
   } eng_st_t;

   typedef enum logic [2:0] {
      S_OFF, S_RST, S_ZERO, S_CTRL, S_WAIT, S_RUN
   } seq_st_t;

   // control word 0: select bit 7 low, wake bit 6 high, current 5:4, level 3:0
   function automatic logic [7:0] make_cw0(input logic [1:0] cur, input logic [3:0] lvl);
      return {1'b0, 1'b1, cur, lvl};
   endfunction

endpackage

// File: rtl/led_seq_phase.sv
module led_seq_phase #(
   parameter int DIV = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   output logic first_o,
   output logic tick_o
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV < 2) begin : g_bad_div
      $error("led_seq_phase: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (restart_i)      cnt_q <= '0;
      else if (!tick_o)        cnt_q <= cnt_q + CW'(1);
   end

   assign first_o = (cnt_q == '0);
   assign tick_o  = (cnt_q == CW'(DIV-1));
endmodule

// File: rtl/led_seq_engine.sv
module led_seq_engine
   import led_seq_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int DIV    = 4,
   localparam int NBW   = $clog2(WORD_W+1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmd_valid_i,
   output logic              cmd_ready_o,
   input  logic [WORD_W-1:0] cmd_data_i,
   input  logic [NBW-1:0]    cmd_nbits_i,
   input  logic              cmd_rs_i,
   input  logic              cmd_last_i,
   output logic              idle_o,
   output logic              rs_o,
   output logic              ce_n_o,
   output logic              sclk_o,
   output logic              din_o
);
   eng_st_t           st_q, st_n;
   logic [WORD_W-1:0] sh_q;
   logic [NBW-1:0]    left_q;
   logic              last_q;
   logic              first, tick;
   logic              acc, end_word;

   led_seq_phase #(.DIV(DIV)) u_phase (
      .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(st_n != st_q),
      .first_o(first), .tick_o(tick)
   );

   assign cmd_ready_o = (st_q == E_IDLE) || (st_q == E_HOLD);
   assign idle_o      = (st_q == E_IDLE);
   assign acc         = cmd_valid_i && cmd_ready_o;
   assign end_word    = (left_q == NBW'(1));

   always_comb begin
      st_n = st_q;
      unique case (st_q)
         E_IDLE:  if (cmd_valid_i) st_n = E_SEL;
         E_SEL:   if (tick) st_n = E_CE;
         E_CE:    if (tick) st_n = E_LOW;
         E_LOW:   if (tick) st_n = E_HIGH;
         E_HIGH:  if (tick) st_n = !end_word ? E_LOW : (last_q ? E_CEUP : E_HOLD);
         E_HOLD:  if (cmd_valid_i) st_n = E_LOW;
         E_CEUP:  if (tick) st_n = E_LATCH;
         E_LATCH: if (tick) st_n = E_IDLE;
         default: st_n = E_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= E_IDLE;
         sh_q   <= '0;
         left_q <= '0;
         last_q <= 1'b0;
         rs_o   <= 1'b0;
         ce_n_o <= 1'b1;
         sclk_o <= 1'b0;
         din_o  <= 1'b0;
      end else begin
         st_q <= st_n;
         if (acc) begin
            sh_q   <= cmd_data_i;
            left_q <= cmd_nbits_i;
            last_q <= cmd_last_i;
            if (st_q == E_IDLE) rs_o <= cmd_rs_i;
         end
         if (st_q == E_SEL && tick) ce_n_o <= 1'b0;
         if (st_q == E_LOW && first) din_o <= sh_q[WORD_W-1];
         if (st_q == E_LOW && tick) sclk_o <= 1'b1;
         if (st_q == E_HIGH && tick) begin
            sh_q   <= sh_q << 1;
            left_q <= left_q - NBW'(1);
            if (end_word && last_q) ce_n_o <= 1'b1;
            else                    sclk_o <= 1'b0;
         end
         if (st_q == E_CEUP && tick) sclk_o <= 1'b0;
      end
   end
endmodule

// File: rtl/led_chain_init_seq.sv
module led_chain_init_seq
   import led_seq_pkg::*;
#(
   parameter int         CHAIN_BITS = 320,
   parameter int         WORD_W     = 8,
   parameter int         DIV        = 4,
   parameter int         RST_HOLD   = 4,
   parameter logic [1:0] CUR_SEL    = 2'b10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [3:0]        bright_i,
   output logic              busy_o,
   input  logic              frm_valid_i,
   input  logic [WORD_W-1:0] frm_data_i,
   output logic              frm_ready_o,
   output logic              disp_rst_n_o,
   output logic              disp_rs_o,
   output logic              disp_ce_n_o,
   output logic              disp_sclk_o,
   output logic              disp_din_o
);
   localparam int WORDS = CHAIN_BITS / WORD_W;
   localparam int WCW   = $clog2(WORDS + 1);
   localparam int NBW   = $clog2(WORD_W + 1);
   localparam int RCW   = $clog2(RST_HOLD + 1);

   if (WORD_W < 8) begin : g_bad_word
      $error("led_chain_init_seq: WORD_W must hold a control word");
   end
   if (CHAIN_BITS % WORD_W != 0) begin : g_bad_chain
      $error("led_chain_init_seq: CHAIN_BITS must be a multiple of WORD_W");
   end
   if (RST_HOLD < 1) begin : g_bad_hold
      $error("led_chain_init_seq: RST_HOLD must be positive");
   end

   seq_st_t           st_q;
   logic [WCW-1:0]    wcnt_q;
   logic [RCW-1:0]    rcnt_q;
   logic [3:0]        bright_q;
   logic              c_valid, c_ready, c_rs, c_last, c_acc, eng_idle;
   logic [WORD_W-1:0] c_data;
   logic [NBW-1:0]    c_nbits;
   logic              wlast;

   assign wlast = (wcnt_q == WCW'(WORDS-1));
   assign c_acc = c_valid && c_ready;

   always_comb begin
      c_valid = 1'b0;
      c_data  = '0;
      c_nbits = NBW'(WORD_W);
      c_rs    = 1'b0;
      c_last  = wlast;
      unique case (st_q)
         S_ZERO: c_valid = 1'b1;
         S_CTRL: begin
            c_valid = 1'b1;
            c_data  = WORD_W'(make_cw0(CUR_SEL, bright_q)) << (WORD_W - 8);
            c_nbits = NBW'(8);
            c_rs    = 1'b1;
            c_last  = 1'b1;
         end
         S_RUN: begin
            c_valid = frm_valid_i;
            c_data  = frm_data_i;
         end
         default: ;
      endcase
   end

   assign frm_ready_o = (st_q == S_RUN) && c_ready;
   assign busy_o      = (st_q == S_RST) || (st_q == S_ZERO) ||
                        (st_q == S_CTRL) || (st_q == S_WAIT);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q         <= S_OFF;
         wcnt_q       <= '0;
         rcnt_q       <= '0;
         bright_q     <= '0;
         disp_rst_n_o <= 1'b0;
      end else begin
         unique case (st_q)
            S_OFF: if (start_i) begin
               st_q     <= S_RST;
               rcnt_q   <= '0;
               bright_q <= bright_i;
            end
            S_RST: begin
               rcnt_q <= rcnt_q + RCW'(1);
               if (rcnt_q == RCW'(RST_HOLD-1)) begin
                  st_q         <= S_ZERO;
                  disp_rst_n_o <= 1'b1;
                  wcnt_q       <= '0;
               end
            end
            S_ZERO: if (c_acc) begin
               wcnt_q <= wlast ? '0 : wcnt_q + WCW'(1);
               if (wlast) st_q <= S_CTRL;
            end
            S_CTRL: if (c_acc) st_q <= S_WAIT;
            S_WAIT: if (eng_idle) st_q <= S_RUN;
            S_RUN: begin
               if (c_acc) begin
                  wcnt_q <= wlast ? '0 : wcnt_q + WCW'(1);
               end else if (start_i && eng_idle && wcnt_q == '0) begin
                  st_q         <= S_RST;
                  rcnt_q       <= '0;
                  bright_q     <= bright_i;
                  disp_rst_n_o <= 1'b0;
               end
            end
            default: st_q <= S_OFF;
         endcase
      end
   end

   led_seq_engine #(.WORD_W(WORD_W), .DIV(DIV)) u_eng (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .cmd_valid_i(c_valid), .cmd_ready_o(c_ready), .cmd_data_i(c_data),
      .cmd_nbits_i(c_nbits), .cmd_rs_i(c_rs), .cmd_last_i(c_last),
      .idle_o(eng_idle), .rs_o(disp_rs_o), .ce_n_o(disp_ce_n_o),
      .sclk_o(disp_sclk_o), .din_o(disp_din_o)
   );
endmodule

// File: rtl/led_chain_init_seq_chk.sv
module led_chain_init_seq_chk #(
   parameter int RST_HOLD = 4
) (
   input logic clk_i,
   input logic rst_ni,
   input logic busy_o,
   input logic frm_ready_o,
   input logic disp_rst_n_o,
   input logic disp_rs_o,
   input logic disp_ce_n_o,
   input logic disp_sclk_o,
   input logic disp_din_o
);
   localparam int LW = $clog2(RST_HOLD + 2);
   logic [LW-1:0] low_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             low_cnt <= '0;
      else if (disp_rst_n_o)   low_cnt <= '0;
      else if (low_cnt != LW'(RST_HOLD)) low_cnt <= low_cnt + LW'(1);
   end

   // R2
   rst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(disp_rst_n_o) |-> (low_cnt >= LW'(RST_HOLD)));

   // R5
   busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> !frm_ready_o);

   // R7
   rs_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (disp_rs_o != $past(disp_rs_o)) |-> (disp_ce_n_o && $past(disp_ce_n_o)));

   // R8
   din_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (disp_din_o != $past(disp_din_o)) |-> (!disp_sclk_o && !$past(disp_sclk_o)));

   // R9
   ce_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(disp_ce_n_o) |-> !disp_sclk_o);

   // R9
   ce_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(disp_ce_n_o) |-> disp_sclk_o);
endmodule

bind led_chain_init_seq led_chain_init_seq_chk #(.RST_HOLD(RST_HOLD)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .frm_ready_o(frm_ready_o),
   .disp_rst_n_o(disp_rst_n_o), .disp_rs_o(disp_rs_o), .disp_ce_n_o(disp_ce_n_o),
   .disp_sclk_o(disp_sclk_o), .disp_din_o(disp_din_o)
);

// File: tb/led_chain_init_seq_tb_top.sv
module led_chain_init_seq_tb_top;
   localparam int CB   = 40;
   localparam int WW   = 8;
   localparam int HOLD = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [3:0] bright = '0;
   logic frm_valid = 1'b0;
   logic [WW-1:0] frm_data = '0;
   logic busy, frm_ready, d_rst_n, d_rs, d_ce_n, d_sclk, d_din;

   always #5 clk = ~clk;

   led_chain_init_seq #(.CHAIN_BITS(CB), .WORD_W(WW), .DIV(3), .RST_HOLD(HOLD),
                        .CUR_SEL(2'b10)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bright_i(bright),
      .busy_o(busy), .frm_valid_i(frm_valid), .frm_data_i(frm_data),
      .frm_ready_o(frm_ready), .disp_rst_n_o(d_rst_n), .disp_rs_o(d_rs),
      .disp_ce_n_o(d_ce_n), .disp_sclk_o(d_sclk), .disp_din_o(d_din)
   );

   typedef struct {
      bit          rs;
      int          n;
      logic [CB-1:0] bits;
      string       req;
   } item_t;

   item_t exp_q[$];
   int n_chk = 0, n_bad = 0;
   int din_viol = 0, rs_viol = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bus monitor: decode transfers and compare with the scoreboard queue
   logic [CB-1:0] cap;
   int cap_n = 0;
   bit cap_rs, pend = 1'b0;

   always @(negedge d_ce_n) begin
      cap = '0; cap_n = 0; cap_rs = d_rs;
   end
   always @(posedge d_sclk) if (!d_ce_n) begin
      cap = {cap[CB-2:0], d_din}; cap_n++;
   end
   always @(posedge d_ce_n) if (rst_n) begin
      chk(d_sclk == 1'b1, "R9 enable rises with clock high", 64'(d_sclk), 64'd1);
      pend = 1'b1;
   end
   always @(negedge d_sclk) if (pend) begin
      item_t e;
      pend = 1'b0;
      chk(d_ce_n == 1'b1, "R9 latch edge with enable high", 64'(d_ce_n), 64'd1);
      if (exp_q.size() == 0) begin
         chk(1'b0, "R6 unexpected transfer", 64'(cap_n), 64'd0);
      end else begin
         e = exp_q.pop_front();
         chk(cap_rs == e.rs, {e.req, " select level"}, 64'(cap_rs), 64'(e.rs));
         chk(cap_n == e.n, {e.req, " bit count"}, 64'(cap_n), 64'(e.n));
         chk(cap == e.bits, {e.req, " bit pattern"}, 64'(cap), 64'(e.bits));
      end
   end
   always @(d_din) if (rst_n && d_sclk) din_viol++;
   always @(d_rs) if (rst_n && !d_ce_n) rs_viol++;

   task automatic do_start(input logic [3:0] b);
      item_t z, c;
      int lows = 0;
      z.rs = 1'b0; z.n = CB; z.bits = '0; z.req = "R3 zero fill";
      c.rs = 1'b1; c.n = 8; c.bits = CB'({1'b0, 1'b1, 2'b10, b}); c.req = "R4 control word";
      exp_q.push_back(z);
      exp_q.push_back(c);
      @(negedge clk); bright = b; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R5 busy after start", 64'(busy), 64'd1);
      while (!d_rst_n) begin lows++; @(negedge clk); end
      chk(lows >= HOLD, "R2 module reset hold", 64'(lows), 64'(HOLD));
   endtask

   task automatic wait_run();
      while (busy) @(negedge clk);
      chk(exp_q.size() == 0, "R4 sequence transfers done", 64'(exp_q.size()), 64'd0);
      chk(frm_ready == 1'b1, "R5 ready after wake", 64'(frm_ready), 64'd1);
   endtask

   task automatic send_frame(input logic [CB-1:0] f, input int gap);
      item_t e;
      e.rs = 1'b0; e.n = CB; e.bits = f; e.req = "R6 frame";
      exp_q.push_back(e);
      for (int w = 0; w < CB/WW; w++) begin
         @(negedge clk); frm_valid = 1'b1; frm_data = f[CB-1-w*WW -: WW];
         while (!frm_ready) @(negedge clk);
         @(negedge clk); frm_valid = 1'b0;
         repeat (gap) @(negedge clk);
      end
      while (!(d_ce_n && !d_sclk && !pend && frm_ready)) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(d_rst_n == 1'b0, "R1 module reset low", 64'(d_rst_n), 64'd0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      chk({d_rst_n, d_ce_n, d_sclk, busy, frm_ready} == 5'b01000,
          "R1 idle outputs", 64'({d_rst_n, d_ce_n, d_sclk, busy, frm_ready}), 64'h8);

      do_start(4'h9);
      // R5: valid during busy is back-pressured
      frm_valid = 1'b1; frm_data = 8'hFF;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk(frm_ready == 1'b0, "R5 ready low while busy", 64'(frm_ready), 64'd0);
      end
      frm_valid = 1'b0;
      // R2: stray start while busy is ignored
      start = 1'b1; @(negedge clk); start = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk(d_rst_n == 1'b1, "R2 start ignored while busy", 64'(d_rst_n), 64'd1);
      end
      wait_run();

      send_frame({CB{1'b1}}, 0);
      send_frame(40'hA55AA55AA5, 3);
      send_frame(40'h0102040810, 1);

      do_start(4'h3);   // R10 restart with new brightness
      wait_run();
      send_frame(40'h80C0E0F0F8, 0);

      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R6 all transfers seen", 64'(exp_q.size()), 64'd0);
      chk(din_viol == 0, "R8 data changes only with clock low", 64'(din_viol), 64'd0);
      chk(rs_viol == 0, "R7 select changes only with enable high", 64'(rs_viol), 64'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule